// File: doc/BRIEF.md
# Quadrature Encoder Emulator

This block turns an unsigned angular position word into the incremental signals that an optical shaft encoder would produce: two quadrature channels and a once-per-revolution index marker. A host sets the resolution of the encoder output independently of the resolution of the position data. The block clamps the encoder setting so that it never exceeds the data setting.

The position is truncated to the effective resolution. The two least significant bits of the truncated value pick one of four quadrature states, so any movement of the position steps the channels through that sequence in order. The index marker is high for exactly one quadrature state, which is a quarter of a cycle of channel A, at truncated position zero.

While the input-valid flag is low, the outputs hold their last state. All outputs are registered, which places every edge on one clock.

Top module: `quad_enc_emu`

## Requirements
- R1: The effective resolution code equals the smaller of `dataRes` and `encRes`. It appears on `effRes` one clock after it is sampled and is updated whatever the state of `inValid`. Codes: 00=10 bits, 01=12 bits, 10=14 bits, 11=16 bits. The line count per revolution is 2^(bits-2).
- R2: For a 16-bit position word, the quadrature count is `posIn >> (2*(3-code))`, where code is the effective code.
- R3: The two least significant bits q of the quadrature count drive the channels as follows: q=00 gives A=0,B=0; q=01 gives A=1,B=0; q=10 gives A=1,B=1; q=11 gives A=0,B=1.
- R4: When the position increases one count at a time, A changes before B (A=0,B=0 goes to A=1,B=0). When it decreases, B changes first (A=0,B=0 goes to A=0,B=1).
- R5: `encIdx` is 1 exactly when the quadrature count is zero. Whenever it is 1, A and B are both 0.
- R6: While `inValid` is 0, `encA`, `encB` and `encIdx` keep their previous values whatever the position and resolution inputs do.
- R7: While `rstN` is low, the outputs show position zero: A=0, B=0, `encIdx`=1 and `effRes`=00.
- R8: A change in the inputs reaches the outputs at the first rising clock edge after it, and no earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| posIn | input | 16 | Unsigned angular position |
| dataRes | input | 2 | Resolution code of the position data |
| encRes | input | 2 | Requested encoder resolution code |
| inValid | input | 1 | Input signal is valid; outputs update only while high |
| encA | output | 1 | Quadrature channel A |
| encB | output | 1 | Quadrature channel B |
| encIdx | output | 1 | Index marker, one quadrature state wide at zero |
| effRes | output | 2 | Effective encoder resolution code |

## Verification
The hardest case to reach is a clamped encoder setting combined with position values near a truncation boundary. The low bits that the effective resolution discards must visibly have no effect on the channels or the index. The stimulus fixes a coarse data resolution while requesting the finest encoder resolution. It then applies positions such as 0x003F and 0x0040 at code 00, checking that the index stays high across all discarded bits and drops at the first retained count. Stepped sweeps in both directions confirm the order of the channel edges.

// File: rtl/qe_pkg.sv
package qe_pkg;
  localparam int NUM_CODES = 4;
  localparam int CODE_W = 2;

  typedef struct packed {
    logic              load;
    logic [CODE_W-1:0] resCode;
  } qeCtrl_t;
endpackage

// File: rtl/qe_ctrl.sv
module qe_ctrl
  import qe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] dataRes,
  input  logic [CODE_W-1:0] encRes,
  input  logic              inValid,
  output qeCtrl_t           ctrl,
  output logic [CODE_W-1:0] effRes
);
  logic [CODE_W-1:0] clampCode;

  always_comb begin
    clampCode    = (encRes > dataRes) ? dataRes : encRes;
    ctrl.resCode = clampCode;
    ctrl.load    = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) effRes <= '0;
    else       effRes <= clampCode;
  end
endmodule

// File: rtl/qe_dp.sv
module qe_dp
  import qe_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posIn,
  input  qeCtrl_t          ctrl,
  output logic             encA,
  output logic             encB,
  output logic             encIdx
);
  localparam int MAX_SHIFT = 2 * (NUM_CODES - 1);

  logic [POS_W-1:0] truncSel [NUM_CODES];
  logic [POS_W-1:0] trunc;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_trunc
    assign truncSel[c] = posIn >> (MAX_SHIFT - 2 * c);
  end

  assign trunc = truncSel[ctrl.resCode];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encA   <= 1'b0;
      encB   <= 1'b0;
      encIdx <= 1'b1;
    end else if (ctrl.load) begin
      encA   <= trunc[1] ^ trunc[0];
      encB   <= trunc[1];
      encIdx <= (trunc == '0);
    end
  end
endmodule

// File: rtl/quad_enc_emu.sv
module quad_enc_emu
  import qe_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posIn,
  input  logic [1:0]       dataRes,
  input  logic [1:0]       encRes,
  input  logic             inValid,
  output logic             encA,
  output logic             encB,
  output logic             encIdx,
  output logic [1:0]       effRes
);
  qeCtrl_t ctrl;

  qe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataRes(dataRes), .encRes(encRes),
    .inValid(inValid), .ctrl(ctrl), .effRes(effRes)
  );

  qe_dp #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .posIn(posIn), .ctrl(ctrl),
    .encA(encA), .encB(encB), .encIdx(encIdx)
  );
endmodule

// File: rtl/quad_enc_emu_chk.sv
module quad_enc_emu_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] dataRes,
  input logic [1:0] encRes,
  input logic       inValid,
  input logic       encA,
  input logic       encB,
  input logic       encIdx,
  input logic [1:0] effRes
);
  // R1
  res_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (effRes <= $past(dataRes)) && (effRes <= $past(encRes)));

  // R5
  idx_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    encIdx |-> (!encA && !encB));

  // R6
  hold_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable({encA, encB, encIdx}));

  // R7
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (encIdx && !encA && !encB && effRes == 2'b00));
endmodule

bind quad_enc_emu quad_enc_emu_chk u_chk (
  .clk(clk), .rstN(rstN), .dataRes(dataRes), .encRes(encRes),
  .inValid(inValid), .encA(encA), .encB(encB), .encIdx(encIdx),
  .effRes(effRes)
);

// File: tb/sim_quad_enc_emu.sv
module sim_quad_enc_emu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] posIn = '0;
  logic [1:0]  dataRes = '0;
  logic [1:0]  encRes = '0;
  logic        inValid = 1'b0;
  logic        encA, encB, encIdx;
  logic [1:0]  effRes;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_enc_emu u0 (
    .clk(clk), .rstN(rstN), .posIn(posIn), .dataRes(dataRes),
    .encRes(encRes), .inValid(inValid), .encA(encA), .encB(encB),
    .encIdx(encIdx), .effRes(effRes)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] minCode(input logic [1:0] d, input logic [1:0] e);
    return (e < d) ? e : d;
  endfunction

  function automatic logic [15:0] qCount(input logic [15:0] p, input logic [1:0] code);
    int sh;
    sh = 6 - 2 * int'(code);
    return p >> sh;
  endfunction

  // expected {A,B,Idx}
  function automatic logic [2:0] expOut(input logic [15:0] p, input logic [1:0] code);
    logic [15:0] q;
    logic a, b;
    q = qCount(p, code);
    case (q[1:0])
      2'b00: begin a = 0; b = 0; end
      2'b01: begin a = 1; b = 0; end
      2'b10: begin a = 1; b = 1; end
      default: begin a = 0; b = 1; end
    endcase
    return {a, b, (q == 16'd0)};
  endfunction

  task automatic apply(input logic [15:0] p, input logic [1:0] d,
                       input logic [1:0] e, input logic v);
    @(negedge clk);
    posIn = p; dataRes = d; encRes = e; inValid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rstN = 0;
    posIn = 16'h1234; inValid = 1;
    repeat (2) @(posedge clk);
    #1;
    // R7
    check("R7", {encA, encB, encIdx}, 3'b001);
    check("R7", effRes, 0);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic t_clamp();
    for (int d = 0; d < 4; d++) begin
      for (int e = 0; e < 4; e++) begin
        apply(16'h0000, 2'(d), 2'(e), 1);
        // R1
        check("R1", effRes, minCode(2'(d), 2'(e)));
      end
    end
  endtask

  task automatic t_truncate();
    logic [15:0] pats [4] = '{16'h0040, 16'h00C0, 16'hABCD, 16'h7FFF};
    for (int i = 0; i < 4; i++) begin
      for (int c = 0; c < 4; c++) begin
        apply(pats[i], 2'd3, 2'(c), 1);
        // R2 R3
        check("R2/R3", {encA, encB, encIdx}, expOut(pats[i], 2'(c)));
      end
    end
  endtask

  task automatic t_direction();
    logic [15:0] p;
    // R4 increasing at 16 bits
    p = 16'h0100;
    apply(p, 2'd3, 2'd3, 1);
    check("R4", {encA, encB}, 2'b00);
    apply(p + 16'd1, 2'd3, 2'd3, 1);
    check("R4", {encA, encB}, 2'b10);
    for (int k = 2; k < 9; k++) begin
      apply(p + 16'(k), 2'd3, 2'd3, 1);
      check("R4", {encA, encB, encIdx}, expOut(p + 16'(k), 2'd3));
    end
    // R4 decreasing at 10 bits (step 64)
    p = 16'h1000;
    apply(p, 2'd0, 2'd0, 1);
    check("R4", {encA, encB}, 2'b00);
    apply(p - 16'd64, 2'd0, 2'd0, 1);
    check("R4", {encA, encB}, 2'b01);
    apply(p - 16'd128, 2'd0, 2'd0, 1);
    check("R4", {encA, encB}, 2'b11);
  endtask

  task automatic t_index();
    // R5 clamp: request 16 bits with 10-bit data, discarded bits ignored
    apply(16'h003F, 2'd0, 2'd3, 1);
    check("R5", {encA, encB, encIdx}, 3'b001);
    apply(16'h0040, 2'd0, 2'd3, 1);
    check("R5", {encA, encB, encIdx}, 3'b100);
    apply(16'h0001, 2'd3, 2'd3, 1);
    check("R5", encIdx, 0);
    apply(16'h0000, 2'd3, 2'd3, 1);
    check("R5", encIdx, 1);
    apply(16'hFFC0, 2'd0, 2'd0, 1);
    check("R5", {encA, encB, encIdx}, 3'b010);
  endtask

  task automatic t_hold();
    apply(16'h0041, 2'd3, 2'd3, 1);
    check("R6", {encA, encB, encIdx}, expOut(16'h0041, 2'd3));
    apply(16'h0000, 2'd3, 2'd3, 0);
    check("R6", {encA, encB, encIdx}, expOut(16'h0041, 2'd3));
    apply(16'h0003, 2'd0, 2'd0, 0);
    check("R6", {encA, encB, encIdx}, expOut(16'h0041, 2'd3));
    check("R1", effRes, 0);
    apply(16'h0003, 2'd3, 2'd3, 1);
    check("R6", {encA, encB, encIdx}, expOut(16'h0003, 2'd3));
  endtask

  task automatic t_latency();
    apply(16'h0000, 2'd3, 2'd3, 1);
    @(negedge clk);
    posIn = 16'h0002;
    #1;
    // R8 no change before the edge
    check("R8", {encA, encB, encIdx}, 3'b001);
    @(posedge clk);
    #1;
    check("R8", {encA, encB, encIdx}, 3'b110);
  endtask

  initial begin
    t_reset();
    t_clamp();
    t_truncate();
    t_direction();
    t_index();
    t_hold();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule